// File: doc/BRIEF.md
# Go-Back-N Link Sender with Route Failover

This block keeps a window of numbered packets in flight over one of several point-to-point links and watches for cumulative acknowledgements. Each request is given a 4-bit sequence number when it is accepted; the requester keeps the packet contents and uses that number to supply them each time the sender asks for a transmission. When no useful acknowledgement arrives within a set number of timer ticks, every unacknowledged packet is sent again, starting from the oldest.

The links are tried in a fixed order of preference given by a parameter. After a fixed number of resend rounds on one link, the whole window moves to the next usable link. A link is never used if it matches the origin of the traffic being forwarded. When no usable link remains, the block reports a failure for the entire window and drops it. Success is reported as soon as the link acknowledges, which says nothing about delivery beyond that hop. A separate in-order check on the receive side accepts only the next expected sequence number and supplies the number to acknowledge.

Top module: `gbn_link_sender`

## Requirements
- R1: After reset, tx_valid and st_valid are low, req_ready is high and rx_ack_seq is 15 (no packet yet received).
- R2: Accepted requests receive sequence numbers 0, 1, 2 and so on, modulo 16, shown on req_seq. Once WIN packets (default 4) are unacknowledged, req_ready stays low.
- R3: Each accepted packet is offered once, in sequence order, on tx_seq and tx_link. An offer is held until tx_ready is high.
- R4: An acknowledgement is valid only if it arrives from the current link and names an outstanding sequence k. It frees every packet up to and including k. In the following cycle, st_valid and st_ok are high, st_seq is k and st_cnt is the number of packets freed. Any other acknowledgement has no effect.
- R5: A timeout occurs when packets are outstanding and TIMEOUT ticks (default 4) pass with no valid acknowledgement. Transmission then restarts from the oldest outstanding sequence.
- R6: After MAX_RETRY resend rounds (default 3) on one link, the next timeout moves the window to the next usable entry of the route list and resends from the oldest. The route list is ROUTE, with entry 0 as the most preferred; the default entries in order are links 2, 0 and 1.
- R7: A route entry equal to the window's origin is skipped. A request whose origin differs from the origin of a non-empty window waits until that window has drained. Origin 3 matches no route entry by default and marks locally produced traffic.
- R8: A timeout that would move past the last route entry raises st_valid with st_ok low. In that status, st_cnt is the number of packets dropped and st_seq is the last sequence dropped. The window then becomes empty.
- R9: Every burst that starts from an empty window begins on the first route entry that its origin allows.
- R10: On the receive side, rx_accept is high only when rx_valid is high and rx_seq equals the next expected number. rx_ack_seq always shows the last sequence accepted.
- R11: If a valid acknowledgement and a timeout fall in the same cycle, the acknowledgement takes effect and no resend starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | New packet request |
| req_origin | input | LINK_W | Link the packet arrived from |
| req_ready | output | 1 | Request can be accepted |
| req_seq | output | 4 | Sequence number given to the accepted request |
| tx_valid | output | 1 | Packet offered for transmission |
| tx_link | output | LINK_W | Link to send it on |
| tx_seq | output | 4 | Sequence number of the offered packet |
| tx_ready | input | 1 | Link takes the offered packet |
| ack_valid | input | 1 | Acknowledgement present |
| ack_link | input | LINK_W | Link that sent the acknowledgement |
| ack_seq | input | 4 | Cumulative acknowledged sequence |
| tick | input | 1 | Timer tick |
| st_valid | output | 1 | Delivery status present |
| st_ok | output | 1 | 1 for delivered, 0 for dropped |
| st_cnt | output | 4 | Packets covered by the status |
| st_seq | output | 4 | Last sequence covered |
| rx_valid | input | 1 | Incoming packet present |
| rx_seq | input | 4 | Incoming sequence number |
| rx_accept | output | 1 | Incoming packet is the next expected one |
| rx_ack_seq | output | 4 | Last in-order sequence received |

## Verification
A corrupted window pointer shows up at once. req_seq jumps, tx_seq repeats or skips a number, or a status reports the wrong count in the cycle after an acknowledgement. A wrong retry or timer count shifts the moment at which tx_valid rises again or tx_link changes, by one or more tick periods. A broken route choice puts tx_link on the origin link or leaves the route order, on the first offer after the change. The bench runs a behavioural model in step with the design and compares every output on every cycle, so any of these faults is reported in the first cycle where it can be seen.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
    localparam int SEQ_W = 4;
    typedef logic [SEQ_W-1:0] seq_t;
endpackage

// File: rtl/gbn_route_pick.sv
module gbn_route_pick #(
    parameter int LINKS = 3,
    parameter int LINK_W = 2,
    parameter logic [LINKS*LINK_W-1:0] ROUTE = 6'b01_00_10,
    parameter int SW = 2
) (
    input  logic [SW-1:0]     start,
    input  logic [LINK_W-1:0] origin,
    output logic [SW-1:0]     idx,
    output logic              found
);
    // Lowest route entry at or after start whose link differs from the origin.
    always_comb begin
        idx = '0;
        found = 1'b0;
        for (int i = LINKS - 1; i >= 0; i--) begin
            if (SW'(i) >= start && ROUTE[i*LINK_W +: LINK_W] != origin) begin
                idx = SW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gbn_rx_order.sv
module gbn_rx_order
    import gbn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  seq_t rx_seq,
    output logic rx_accept,
    output seq_t rx_ack_seq
);
    seq_t exp_d, exp_q;

    always_comb begin
        rx_accept = rx_valid && (rx_seq == exp_q);
        exp_d = exp_q + seq_t'(rx_accept);
        rx_ack_seq = exp_q - seq_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_q <= '0;
        else        exp_q <= exp_d;
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_accept |=> $stable(rx_ack_seq)); // R10
endmodule

// File: rtl/gbn_link_sender.sv
module gbn_link_sender
    import gbn_pkg::*;
#(
    parameter int WIN = 4,
    parameter int LINKS = 3,
    parameter int LINK_W = 2,
    parameter logic [LINKS*LINK_W-1:0] ROUTE = 6'b01_00_10,
    parameter int MAX_RETRY = 3,
    parameter int TIMEOUT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LINK_W-1:0] req_origin,
    output logic              req_ready,
    output logic [3:0]        req_seq,
    output logic              tx_valid,
    output logic [LINK_W-1:0] tx_link,
    output logic [3:0]        tx_seq,
    input  logic              tx_ready,
    input  logic              ack_valid,
    input  logic [LINK_W-1:0] ack_link,
    input  logic [3:0]        ack_seq,
    input  logic              tick,
    output logic              st_valid,
    output logic              st_ok,
    output logic [3:0]        st_cnt,
    output logic [3:0]        st_seq,
    input  logic              rx_valid,
    input  logic [3:0]        rx_seq,
    output logic              rx_accept,
    output logic [3:0]        rx_ack_seq
);
    localparam int SW  = $clog2(LINKS + 1);
    localparam int TW  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam int RTW = $clog2(MAX_RETRY + 1);
    localparam logic [TW-1:0]  TMO_LAST = TW'(TIMEOUT - 1);
    localparam logic [RTW-1:0] RETRY_TOP = RTW'(MAX_RETRY);

    typedef struct packed {
        seq_t              base;
        seq_t              nxt;
        seq_t              head;
        logic [SW-1:0]     ri;
        logic [LINK_W-1:0] worg;
        logic [RTW-1:0]    retry;
        logic [TW-1:0]     tcnt;
        logic              st_vld;
        logic              st_ok;
        seq_t              st_cnt;
        seq_t              st_seq;
    } state_t;

    state_t s_d, s_q;

    seq_t              cnt, ack_off, nxt_off;
    logic [LINK_W-1:0] cur_link;
    logic              ack_ok, tmo, fail_now, acc, fire;
    logic [SW-1:0]     first_idx, fo_idx;
    logic              first_found, fo_found;

    gbn_route_pick #(.LINKS(LINKS), .LINK_W(LINK_W), .ROUTE(ROUTE), .SW(SW)) u_pick_first (
        .start (SW'(0)),
        .origin(req_origin),
        .idx   (first_idx),
        .found (first_found)
    );

    gbn_route_pick #(.LINKS(LINKS), .LINK_W(LINK_W), .ROUTE(ROUTE), .SW(SW)) u_pick_next (
        .start (s_q.ri + SW'(1)),
        .origin(s_q.worg),
        .idx   (fo_idx),
        .found (fo_found)
    );

    gbn_rx_order u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_seq    (rx_seq),
        .rx_accept (rx_accept),
        .rx_ack_seq(rx_ack_seq)
    );

    always_comb begin
        cnt      = s_q.head - s_q.base;
        ack_off  = ack_seq - s_q.base;
        nxt_off  = s_q.nxt - s_q.base;
        cur_link = ROUTE[int'(s_q.ri)*LINK_W +: LINK_W];
        ack_ok   = ack_valid && (cnt != '0) && (ack_link == cur_link) && (ack_off < cnt);
        tmo      = tick && (cnt != '0) && (s_q.tcnt == TMO_LAST) && !ack_ok;
        fail_now = tmo && (s_q.retry == RETRY_TOP) && !fo_found;
        req_ready = (cnt < seq_t'(WIN)) && ((cnt == '0) || (req_origin == s_q.worg)) && !fail_now;
        acc      = req_valid && req_ready;
        tx_valid = (s_q.nxt != s_q.head);
        fire     = tx_valid && tx_ready;

        s_d = s_q;
        s_d.st_vld = 1'b0;
        s_d.head = s_q.head + seq_t'(acc);

        if (acc && cnt == '0) begin
            s_d.ri    = first_found ? first_idx : '0;
            s_d.worg  = req_origin;
            s_d.retry = '0;
        end
        if (cnt == '0) s_d.tcnt = '0;

        if (ack_ok) begin
            s_d.base   = ack_seq + seq_t'(1);
            s_d.nxt    = (nxt_off <= ack_off) ? ack_seq + seq_t'(1) : s_q.nxt + seq_t'(fire);
            s_d.retry  = '0;
            s_d.tcnt   = '0;
            s_d.st_vld = 1'b1;
            s_d.st_ok  = 1'b1;
            s_d.st_cnt = ack_off + seq_t'(1);
            s_d.st_seq = ack_seq;
        end else if (tmo) begin
            s_d.tcnt = '0;
            s_d.nxt  = s_q.base;
            if (s_q.retry != RETRY_TOP) begin
                s_d.retry = s_q.retry + RTW'(1);
            end else if (fo_found) begin
                s_d.ri    = fo_idx;
                s_d.retry = '0;
            end else begin
                s_d.base   = s_q.head;
                s_d.nxt    = s_q.head;
                s_d.retry  = '0;
                s_d.st_vld = 1'b1;
                s_d.st_ok  = 1'b0;
                s_d.st_cnt = cnt;
                s_d.st_seq = s_q.head - seq_t'(1);
            end
        end else begin
            s_d.nxt = s_q.nxt + seq_t'(fire);
            if (tick && cnt != '0) s_d.tcnt = s_q.tcnt + TW'(1);
        end

        req_seq  = s_q.head;
        tx_seq   = s_q.nxt;
        tx_link  = cur_link;
        st_valid = s_q.st_vld;
        st_ok    = s_q.st_ok;
        st_cnt   = s_q.st_cnt;
        st_seq   = s_q.st_seq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= seq_t'(WIN)); // R2
    AST_ACK_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> (st_valid && st_ok)); // R4
    AST_GO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (tx_seq == s_q.base)); // R5
    AST_NOT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_link != s_q.worg)); // R7
    AST_FAIL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ok) |-> (!tx_valid && req_ready)); // R8
endmodule

// File: tb/test_gbn_link_sender.sv
module test_gbn_link_sender;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, tx_ready = 0, ack_valid = 0, tick = 0, rx_valid = 0;
    logic [1:0] req_origin = 2'd3, ack_link = 0;
    logic [3:0] ack_seq = 0, rx_seq = 0;
    logic req_ready, tx_valid, st_valid, st_ok, rx_accept;
    logic [1:0] tx_link;
    logic [3:0] req_seq, tx_seq, st_cnt, st_seq, rx_ack_seq;

    always #2 clk = ~clk;

    gbn_link_sender i_gbn_link_sender (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_origin(req_origin),
        .req_ready(req_ready), .req_seq(req_seq), .tx_valid(tx_valid), .tx_link(tx_link),
        .tx_seq(tx_seq), .tx_ready(tx_ready), .ack_valid(ack_valid), .ack_link(ack_link),
        .ack_seq(ack_seq), .tick(tick), .st_valid(st_valid), .st_ok(st_ok),
        .st_cnt(st_cnt), .st_seq(st_seq), .rx_valid(rx_valid), .rx_seq(rx_seq),
        .rx_accept(rx_accept), .rx_ack_seq(rx_ack_seq)
    );

    int checks = 0, fails = 0;
    bit done = 0, mon_en = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: unbounded integer counters, sequence = value mod 16.
    int rt [3] = '{2, 0, 1};
    int mbase = 0, mnxt = 0, mhead = 0, mri = 0, mworg = 0, mretry = 0, mtcnt = 0;
    int mst_v = 0, mst_ok = 0, mst_cnt = 0, mst_seq = 0, mexp = 0, coincide = 0;
    int c_cnt, c_link, c_fo, c_d;
    bit c_ack, c_tmo, c_fail, c_ready, c_txv;

    function automatic int pick(input int start, input int org);
        for (int i = start; i < 3; i++) if (rt[i] != org) return i;
        return -1;
    endfunction

    task automatic model_comb();
        c_cnt = mhead - mbase;
        c_link = rt[mri];
        c_d = (int'(ack_seq) - (mbase % 16) + 16) % 16;
        c_ack = ack_valid && c_cnt > 0 && int'(ack_link) == c_link && c_d < c_cnt;
        c_tmo = tick && c_cnt > 0 && mtcnt == 3 && !c_ack;
        c_fo = pick(mri + 1, mworg);
        c_fail = c_tmo && mretry == 3 && c_fo < 0;
        c_ready = c_cnt < 4 && (c_cnt == 0 || int'(req_origin) == mworg) && !c_fail;
        c_txv = mnxt != mhead;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mbase = 0; mnxt = 0; mhead = 0; mri = 0; mworg = 0; mretry = 0; mtcnt = 0;
            mst_v = 0; mst_ok = 0; mst_cnt = 0; mst_seq = 0; mexp = 0;
        end else begin
            bit acc, fire, rxa;
            model_comb();
            acc = req_valid && c_ready;
            fire = c_txv && tx_ready;
            rxa = rx_valid && int'(rx_seq) == mexp % 16;
            mst_v = 0;
            if (acc && c_cnt == 0) begin
                mri = pick(0, int'(req_origin)); mworg = int'(req_origin); mretry = 0;
            end
            if (c_cnt == 0) mtcnt = 0;
            if (c_ack) begin
                int nb;
                if (tick && mtcnt == 3) coincide++;
                nb = mbase + c_d + 1;
                if (mnxt < nb) mnxt = nb; else mnxt += int'(fire);
                mbase = nb; mretry = 0; mtcnt = 0;
                mst_v = 1; mst_ok = 1; mst_cnt = c_d + 1; mst_seq = int'(ack_seq);
            end else if (c_tmo) begin
                mtcnt = 0; mnxt = mbase;
                if (mretry < 3) mretry++;
                else if (c_fo >= 0) begin mri = c_fo; mretry = 0; end
                else begin
                    mst_v = 1; mst_ok = 0; mst_cnt = c_cnt; mst_seq = (mhead - 1) % 16;
                    mbase = mhead; mnxt = mhead; mretry = 0;
                end
            end else begin
                if (fire) mnxt++;
                if (tick && c_cnt > 0) mtcnt++;
            end
            if (acc) mhead++;
            if (rxa) mexp++;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && mon_en) begin
            model_comb();
            chk("R2 req_ready", int'(req_ready), int'(c_ready));
            chk("R2 req_seq", int'(req_seq), mhead % 16);
            chk("R3 tx_valid", int'(tx_valid), int'(c_txv));
            if (c_txv) begin
                chk("R3 tx_seq", int'(tx_seq), mnxt % 16);
                chk("R6 tx_link", int'(tx_link), c_link);
            end
            chk("R4 st_valid", int'(st_valid), mst_v);
            if (mst_v) begin
                chk("R8 st_ok", int'(st_ok), mst_ok);
                chk("R4 st_cnt", int'(st_cnt), mst_cnt);
                chk("R4 st_seq", int'(st_seq), mst_seq);
            end
            chk("R10 rx_accept", int'(rx_accept), int'(rx_valid && int'(rx_seq) == mexp % 16));
            chk("R10 rx_ack_seq", int'(rx_ack_seq), (mexp + 15) % 16);
        end
    end

    task automatic idle();
        req_valid = 0; ack_valid = 0; rx_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_en = 1;
        @(negedge clk); #1;
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 st_valid", int'(st_valid), 0);
        chk("R1 rx_ack_seq", int'(rx_ack_seq), 15);

        // Fill the window while the link is busy.
        tx_ready = 0; req_origin = 3;
        repeat (4) begin @(negedge clk); req_valid = 1; end
        @(negedge clk); req_valid = 1; #1;
        chk("R2 full window blocks", int'(req_ready), 0);
        chk("R3 first link", int'(tx_link), 2);
        @(negedge clk); req_valid = 0; tx_ready = 1;
        repeat (4) @(negedge clk);
        // Wrong-link ack ignored.
        ack_valid = 1; ack_link = 0; ack_seq = 3;
        @(negedge clk); ack_valid = 0; #1;
        chk("R4 foreign ack ignored", int'(st_valid), 0);
        @(negedge clk); ack_valid = 1; ack_link = 2; ack_seq = 1;
        @(negedge clk); ack_valid = 0; #1;
        chk("R4 partial ack count", int'(st_cnt), 2);
        @(negedge clk); ack_valid = 1; ack_seq = 3;
        @(negedge clk); ack_valid = 0; #1;
        chk("R4 final ack count", int'(st_cnt), 2);

        // Timeouts, failover and exhaustion.
        begin
            bit sent5 = 0, goback = 0, saw0 = 0, saw1 = 0, failed = 0;
            int fcnt = -1, fseq = -1;
            tick = 1;
            repeat (2) begin @(negedge clk); req_valid = 1; end
            @(negedge clk); req_valid = 0;
            for (int i = 0; i < 200 && !failed; i++) begin
                @(negedge clk); #1;
                if (tx_valid && tx_seq == 4 && sent5) goback = 1;
                if (tx_valid && tx_seq == 5) sent5 = 1;
                if (tx_valid && tx_link == 0) saw0 = 1;
                if (tx_valid && tx_link == 1 && saw0) saw1 = 1;
                if (st_valid && !st_ok) begin failed = 1; fcnt = st_cnt; fseq = st_seq; end
            end
            chk("R5 resend from oldest", int'(goback), 1);
            chk("R6 moved through routes", int'(saw0 && saw1), 1);
            chk("R8 failure count", fcnt, 2);
            chk("R8 failure last seq", fseq, 5);
            tick = 0;
        end

        // New burst starts at the top of the route list.
        @(negedge clk); req_valid = 1; req_origin = 3;
        @(negedge clk); req_valid = 0; #1;
        chk("R9 restart on first route", int'(tx_link), 2);
        @(negedge clk); ack_valid = 1; ack_link = 2; ack_seq = 6;
        @(negedge clk); ack_valid = 0;

        // Origin link is skipped; other origins wait.
        @(negedge clk); req_valid = 1; req_origin = 2;
        @(negedge clk); req_origin = 0; #1;
        chk("R7 origin skipped", int'(tx_link), 0);
        chk("R7 other origin waits", int'(req_ready), 0);
        req_valid = 0;
        @(negedge clk); ack_valid = 1; ack_link = 0; ack_seq = 7;
        @(negedge clk); ack_valid = 0;

        // Ack in the same cycle as a timeout.
        tick = 1; req_origin = 3;
        repeat (2) begin @(negedge clk); req_valid = 1; end
        @(negedge clk); req_valid = 0;
        while (mtcnt != 3) @(negedge clk);
        ack_valid = 1; ack_link = 2; ack_seq = 8;
        @(negedge clk); ack_valid = 0; tick = 0; #1;
        chk("R11 no resend after ack", int'(tx_valid), 0);
        chk("R11 coincidence hit", int'(coincide > 0), 1);
        @(negedge clk); ack_valid = 1; ack_seq = 9;
        @(negedge clk); ack_valid = 0;

        // Receive order check.
        begin
            int k = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk); rx_valid = 1;
                if (i % 5 == 3) rx_seq = 4'((k + 2) % 16);
                else begin rx_seq = 4'(k % 16); k++; end
            end
            @(negedge clk); rx_valid = 0; #1;
            chk("R10 in-order count", int'(rx_ack_seq), (k - 1) % 16);
        end

        // Mixed random traffic.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            req_valid = ($urandom % 3) == 0;
            case ($urandom % 6)
                0: req_origin = 2;
                1: req_origin = 0;
                default: req_origin = 3;
            endcase
            tx_ready = ($urandom % 4) != 0;
            tick = ($urandom % 3) == 0;
            ack_valid = ($urandom % 4) == 0;
            ack_link = (($urandom % 4) != 0) ? 2'(rt[mri]) : 2'($urandom % 4);
            ack_seq = 4'((mbase % 16) + ($urandom % 6));
            rx_valid = $urandom % 2;
            rx_seq = (($urandom % 3) != 0) ? 4'(mexp % 16) : 4'($urandom % 16);
        end
        @(negedge clk); idle(); tick = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule